// File: doc/BRIEF.md
# Predicated Vector Branch Side-Effect Resolver

This block settles what a single tested element of a predicated vector branch does to the architectural state around it. For each element strobe it receives the branch test outcome, the element's predicate bit, the element index, the current and maximum vector lengths, the return address, the current count value and a set of mode bits. It then decides three things. Is the link register written? Is the vector length cut short, and to what value? Is the count register the only thing changed?

The result is registered. One cycle after an input strobe, `out_vld` pulses once. With it come the write enables and next values for the link register, the vector length and the count register, plus a redirect flag that says the branch would be taken. Fetch, decode, target computation and the actual PC redirect belong to the surrounding pipeline.

Mode bits used below:
- `link_req` asks for a link write.
- `link_gated` ties that write to the test outcome.
- `cut_on_pass` picks whether a passing or a failing test cuts the vector length.
- `keep_elem` keeps the current element inside the cut length.
- `vl_cut_mode` enables length cutting.
- `cnt_only_mode` selects counter-test behaviour.

Top module: `vbr_side_effect_unit`

## Requirements
- R1: With `link_req`=1 and `link_gated`=0, an active element writes the link register (`link_we`=1, `link_wdata`=`ret_addr`) whatever `cond_pass` is.
- R2: With `link_req`=1 and `link_gated`=1, an active element writes the link register only when `cond_pass`=1.
- R3: With `link_req`=0 and `link_gated`=1, an active element writes the link register only when `cond_pass`=0.
- R4: With `link_req`=0 and `link_gated`=0, the link register is never written.
- R5: Vector length cutting is considered only when `vl_cut_mode`=1. It triggers when `cond_pass` equals `cut_on_pass`: a passing test cuts when `cut_on_pass`=1, and a failing test cuts when `cut_on_pass`=0.
- R6: The cut length is `elem_idx` when `keep_elem`=0, which excludes the current element. It is `elem_idx`+1 when `keep_elem`=1, which includes it.
- R7: The effective length is min(`cur_vl`, `max_vl`). A cut length that is not strictly below the effective length produces no vector length write. `max_vl` is read only, and there is no output that changes it.
- R8: With `cnt_only_mode`=1, an active element raises only `cnt_we`, with `cnt_wdata` = `cur_cnt`-1 (wrapping modulo 2^CNT_W). `link_we`, `vl_we` and `redir_en` stay 0. With `cnt_only_mode`=0, `cnt_we` stays 0.
- R9: An element with `elem_on`=0 (masked out) produces no write enable and no redirect, but still produces its `out_vld` pulse.
- R10: Outputs are registered. `out_vld` is high exactly in the cycle after an `in_vld` cycle. Every data output reads 0 whenever its enable is low. After reset all outputs are 0.
- R11: Outside counter-test mode, an active element has `redir_en` equal to `cond_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Element strobe |
| cond_pass | input | 1 | Branch test outcome for this element |
| elem_on | input | 1 | Predicate bit; 0 means masked out |
| elem_idx | input | VL_W | Element index |
| cur_vl | input | VL_W | Current vector length |
| max_vl | input | VL_W | Maximum vector length (read only) |
| link_req | input | 1 | Link write requested |
| link_gated | input | 1 | Link write tied to the test outcome |
| cut_on_pass | input | 1 | 1: cut on pass, 0: cut on fail |
| keep_elem | input | 1 | Keep the current element in the cut length |
| vl_cut_mode | input | 1 | Enable vector length cutting |
| cnt_only_mode | input | 1 | Counter-test mode |
| ret_addr | input | ADDR_W | Return address for the link register |
| cur_cnt | input | CNT_W | Current count register value |
| out_vld | output | 1 | Result valid |
| link_we | output | 1 | Link register write enable |
| link_wdata | output | ADDR_W | Link register next value |
| vl_we | output | 1 | Vector length write enable |
| vl_wdata | output | VL_W | Vector length next value |
| cnt_we | output | 1 | Count register write enable |
| cnt_wdata | output | CNT_W | Count register next value |
| redir_en | output | 1 | Branch would be taken |

## Verification
Random elements sweep all 64 combinations of the six mode bits against both test outcomes, which separates the four link cases from each other and both cut polarities from each other. Random indices against random current and maximum lengths tell apart a real cut, a cut that is not strictly lower, and a cut clamped by a smaller maximum. Directed cases pin down:
- the cut at index 0 and at the last element;
- a counter wrap from zero;
- masked elements carrying every mode bit set;
- the idle cycle between strobes, which shows the single-pulse handshake.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

  typedef struct packed {
    logic link_req;
    logic link_gated;
    logic cut_on_pass;
    logic keep_elem;
    logic vl_cut_mode;
    logic cnt_only_mode;
  } vbr_mode_t;

  typedef enum logic [1:0] {
    LINK_NEVER   = 2'b00,
    LINK_ON_FAIL = 2'b01,
    LINK_ALWAYS  = 2'b10,
    LINK_ON_PASS = 2'b11
  } vbr_link_pol_e;

endpackage

// File: rtl/vbr_rst_sync.sv
module vbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/vbr_link_decide.sv
module vbr_link_decide
  import vbr_pkg::*;
(
  input  logic      active,
  input  logic      cond_pass,
  input  vbr_mode_t mode,
  output logic      link_fire
);
  vbr_link_pol_e pol;

  always_comb begin
    pol = vbr_link_pol_e'({mode.link_req, mode.link_gated});
    unique case (pol)
      LINK_ALWAYS:  link_fire = 1'b1;
      LINK_ON_PASS: link_fire = cond_pass;
      LINK_ON_FAIL: link_fire = ~cond_pass;
      default:      link_fire = 1'b0;
    endcase
    link_fire = link_fire & active & ~mode.cnt_only_mode;
  end
endmodule

// File: rtl/vbr_vl_trunc.sv
module vbr_vl_trunc
  import vbr_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            active,
  input  logic            cond_pass,
  input  vbr_mode_t       mode,
  input  logic [VL_W-1:0] elem_idx,
  input  logic [VL_W-1:0] cur_vl,
  input  logic [VL_W-1:0] max_vl,
  output logic            vl_fire,
  output logic [VL_W-1:0] vl_new
);
  localparam int WIDE_W = VL_W + 1;

  logic [WIDE_W-1:0] cand;
  logic [WIDE_W-1:0] eff_vl;
  logic              trigger;

  always_comb begin
    cand    = {1'b0, elem_idx} + {{VL_W{1'b0}}, mode.keep_elem};
    eff_vl  = (cur_vl < max_vl) ? {1'b0, cur_vl} : {1'b0, max_vl};
    trigger = active & mode.vl_cut_mode & ~mode.cnt_only_mode
              & (cond_pass == mode.cut_on_pass);
    vl_fire = trigger & (cand < eff_vl);
    vl_new  = cand[VL_W-1:0];
  end
endmodule

// File: rtl/vbr_cnt_step.sv
module vbr_cnt_step
  import vbr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             active,
  input  vbr_mode_t        mode,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic             cnt_fire,
  output logic [CNT_W-1:0] cnt_new
);
  always_comb begin
    cnt_fire = active & mode.cnt_only_mode;
    cnt_new  = cur_cnt - {{(CNT_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/vbr_side_effect_unit.sv
module vbr_side_effect_unit
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VL_MAX = 64,
  parameter int CNT_W  = 64,
  parameter int VL_W   = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              cond_pass,
  input  logic              elem_on,
  input  logic [VL_W-1:0]   elem_idx,
  input  logic [VL_W-1:0]   cur_vl,
  input  logic [VL_W-1:0]   max_vl,
  input  logic              link_req,
  input  logic              link_gated,
  input  logic              cut_on_pass,
  input  logic              keep_elem,
  input  logic              vl_cut_mode,
  input  logic              cnt_only_mode,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic              out_vld,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_wdata,
  output logic              vl_we,
  output logic [VL_W-1:0]   vl_wdata,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              redir_en
);
  vbr_mode_t         mode;
  logic              rst_q_n;
  logic              active;
  logic              link_fire;
  logic              vl_fire;
  logic [VL_W-1:0]   vl_new;
  logic              cnt_fire;
  logic [CNT_W-1:0]  cnt_new;

  logic              vld_d, link_we_d, vl_we_d, cnt_we_d, redir_d;
  logic [ADDR_W-1:0] link_data_d;
  logic [VL_W-1:0]   vl_data_d;
  logic [CNT_W-1:0]  cnt_data_d;
  logic              reg_en;

  vbr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    mode.link_req      = link_req;
    mode.link_gated    = link_gated;
    mode.cut_on_pass   = cut_on_pass;
    mode.keep_elem     = keep_elem;
    mode.vl_cut_mode   = vl_cut_mode;
    mode.cnt_only_mode = cnt_only_mode;
    active             = in_vld & elem_on;
  end

  vbr_link_decide u_link (
    .active(active), .cond_pass(cond_pass), .mode(mode), .link_fire(link_fire)
  );

  vbr_vl_trunc #(.VL_W(VL_W)) u_trunc (
    .active(active), .cond_pass(cond_pass), .mode(mode),
    .elem_idx(elem_idx), .cur_vl(cur_vl), .max_vl(max_vl),
    .vl_fire(vl_fire), .vl_new(vl_new)
  );

  vbr_cnt_step #(.CNT_W(CNT_W)) u_cnt (
    .active(active), .mode(mode), .cur_cnt(cur_cnt),
    .cnt_fire(cnt_fire), .cnt_new(cnt_new)
  );

  // next-state
  always_comb begin
    vld_d       = in_vld;
    link_we_d   = link_fire;
    link_data_d = link_fire ? ret_addr : '0;
    vl_we_d     = vl_fire;
    vl_data_d   = vl_fire ? vl_new : '0;
    cnt_we_d    = cnt_fire;
    cnt_data_d  = cnt_fire ? cnt_new : '0;
    redir_d     = active & ~cnt_only_mode & cond_pass;
    reg_en      = in_vld | out_vld;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_vld    <= 1'b0;
      link_we    <= 1'b0;
      link_wdata <= '0;
      vl_we      <= 1'b0;
      vl_wdata   <= '0;
      cnt_we     <= 1'b0;
      cnt_wdata  <= '0;
      redir_en   <= 1'b0;
    end else if (reg_en) begin
      out_vld    <= vld_d;
      link_we    <= link_we_d;
      link_wdata <= link_data_d;
      vl_we      <= vl_we_d;
      vl_wdata   <= vl_data_d;
      cnt_we     <= cnt_we_d;
      cnt_wdata  <= cnt_data_d;
      redir_en   <= redir_d;
    end
  end
endmodule

// File: rtl/vbr_side_effect_chk.sv
module vbr_side_effect_chk #(
  parameter int ADDR_W = 64,
  parameter int VL_W   = 7,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              in_vld,
  input logic              cond_pass,
  input logic              elem_on,
  input logic [VL_W-1:0]   cur_vl,
  input logic              link_req,
  input logic              link_gated,
  input logic              cnt_only_mode,
  input logic [ADDR_W-1:0] ret_addr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic              out_vld,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_wdata,
  input logic              vl_we,
  input logic [VL_W-1:0]   vl_wdata,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              redir_en
);
  AST_LINK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && elem_on && link_req && !link_gated && !cnt_only_mode
    |=> link_we && link_wdata == $past(ret_addr)); // R1
  AST_LINK_NOT_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && link_req && link_gated && !cond_pass |=> !link_we); // R2
  AST_LINK_NOT_ON_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && !link_req && link_gated && cond_pass |=> !link_we); // R3
  AST_LINK_NEVER: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && !link_req && !link_gated |=> !link_we); // R4
  AST_VL_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld |=> !vl_we || vl_wdata < $past(cur_vl)); // R7
  AST_CNT_ONLY: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && elem_on && cnt_only_mode
    |=> cnt_we && cnt_wdata == $past(cur_cnt) - 1'b1 && !link_we && !vl_we && !redir_en); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_vld && !elem_on |=> out_vld && !link_we && !vl_we && !cnt_we && !redir_en); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_vld |=> !out_vld && !link_we && !vl_we && !cnt_we && !redir_en); // R10
endmodule

bind vbr_side_effect_unit vbr_side_effect_chk #(
  .ADDR_W(ADDR_W), .VL_W(VL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_vld(in_vld), .cond_pass(cond_pass),
  .elem_on(elem_on), .cur_vl(cur_vl), .link_req(link_req),
  .link_gated(link_gated), .cnt_only_mode(cnt_only_mode),
  .ret_addr(ret_addr), .cur_cnt(cur_cnt), .out_vld(out_vld),
  .link_we(link_we), .link_wdata(link_wdata), .vl_we(vl_we),
  .vl_wdata(vl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .redir_en(redir_en)
);

// File: tb/vbr_side_effect_unit_tb.sv
module vbr_side_effect_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int VL_MAX = 64;
  localparam int CNT_W  = 64;
  localparam int VL_W   = $clog2(VL_MAX + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld, cond_pass, elem_on;
  logic [VL_W-1:0] elem_idx, cur_vl, max_vl;
  logic link_req, link_gated, cut_on_pass, keep_elem, vl_cut_mode, cnt_only_mode;
  logic [ADDR_W-1:0] ret_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic out_vld, link_we, vl_we, cnt_we, redir_en;
  logic [ADDR_W-1:0] link_wdata;
  logic [VL_W-1:0]   vl_wdata;
  logic [CNT_W-1:0]  cnt_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbr_side_effect_unit #(.ADDR_W(ADDR_W), .VL_MAX(VL_MAX), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cond_pass(cond_pass),
    .elem_on(elem_on), .elem_idx(elem_idx), .cur_vl(cur_vl), .max_vl(max_vl),
    .link_req(link_req), .link_gated(link_gated), .cut_on_pass(cut_on_pass),
    .keep_elem(keep_elem), .vl_cut_mode(vl_cut_mode), .cnt_only_mode(cnt_only_mode),
    .ret_addr(ret_addr), .cur_cnt(cur_cnt), .out_vld(out_vld),
    .link_we(link_we), .link_wdata(link_wdata), .vl_we(vl_we), .vl_wdata(vl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .redir_en(redir_en)
  );

  // expected values
  logic            e_link, e_vl, e_cnt, e_redir;
  logic [ADDR_W-1:0] e_link_d;
  logic [VL_W-1:0]   e_vl_d;
  logic [CNT_W-1:0]  e_cnt_d;

  function automatic logic link_model(logic lr, logic lg, logic c);
    if (lr && !lg) return 1'b1;
    if (lr && lg)  return c;
    if (!lr && lg) return !c;
    return 1'b0;
  endfunction

  task automatic compute_expect();
    int eff, cand;
    e_link = 0; e_vl = 0; e_cnt = 0; e_redir = 0;
    e_link_d = '0; e_vl_d = '0; e_cnt_d = '0;
    if (elem_on) begin
      if (cnt_only_mode) begin
        e_cnt = 1; e_cnt_d = cur_cnt - 1;
      end else begin
        e_redir = cond_pass;
        e_link  = link_model(link_req, link_gated, cond_pass);
        if (e_link) e_link_d = ret_addr;
        if (vl_cut_mode && (cond_pass == cut_on_pass)) begin
          eff  = (int'(cur_vl) < int'(max_vl)) ? int'(cur_vl) : int'(max_vl);
          cand = int'(elem_idx) + (keep_elem ? 1 : 0);
          if (cand < eff) begin e_vl = 1; e_vl_d = VL_W'(cand); end
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pick_tag(output string t);
    if (!elem_on)           t = "R9";
    else if (cnt_only_mode) t = "R8";
    else if (vl_cut_mode)   t = "R5/R6/R7";
    else if (link_req && !link_gated) t = "R1";
    else if (link_req)      t = "R2";
    else if (link_gated)    t = "R3";
    else                    t = "R4";
  endtask

  task automatic send(string tag);
    @(negedge clk);
    chk("R10 idle out_vld", 64'(out_vld), 64'd0);
    in_vld = 1'b1;
    compute_expect();
    @(negedge clk);
    in_vld = 1'b0;
    chk({tag, " out_vld"}, 64'(out_vld), 64'd1);
    chk({tag, " link_we"}, 64'(link_we), 64'(e_link));
    chk({tag, " link_wdata"}, link_wdata, e_link_d);
    chk({tag, " vl_we"}, 64'(vl_we), 64'(e_vl));
    chk({tag, " vl_wdata"}, 64'(vl_wdata), 64'(e_vl_d));
    chk({tag, " cnt_we"}, 64'(cnt_we), 64'(e_cnt));
    chk({tag, " cnt_wdata"}, cnt_wdata, e_cnt_d);
    chk({tag, " R11 redir_en"}, 64'(redir_en), 64'(e_redir));
  endtask

  task automatic set_mode(logic [5:0] m);
    {link_req, link_gated, cut_on_pass, keep_elem, vl_cut_mode, cnt_only_mode} = m;
  endtask

  initial begin
    string t;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_vld = 0; cond_pass = 0; elem_on = 0;
    elem_idx = 0; cur_vl = 0; max_vl = 0; set_mode(6'd0);
    ret_addr = 0; cur_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_vld", 64'(out_vld), 0);
    chk("R10 reset link_wdata", link_wdata, 0);
    chk("R10 reset cnt_we", 64'(cnt_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    ret_addr = 64'hDEAD_BEEF_0000_1230; cur_cnt = 64'd9; elem_on = 1;
    cur_vl = 7'd40; max_vl = 7'd64; elem_idx = 7'd10;
    // link cases, both outcomes
    set_mode(6'b10_0000); cond_pass = 0; send("R1");
    set_mode(6'b10_0000); cond_pass = 1; send("R1");
    set_mode(6'b11_0000); cond_pass = 1; send("R2");
    set_mode(6'b11_0000); cond_pass = 0; send("R2");
    set_mode(6'b01_0000); cond_pass = 0; send("R3");
    set_mode(6'b01_0000); cond_pass = 1; send("R3");
    set_mode(6'b00_0000); cond_pass = 1; send("R4");
    // cut polarity and inclusion
    set_mode(6'b00_1010); cond_pass = 1; send("R5 cut on pass");
    set_mode(6'b00_0010); cond_pass = 1; send("R5 no cut on pass");
    set_mode(6'b00_0010); cond_pass = 0; send("R5 cut on fail");
    set_mode(6'b00_1110); cond_pass = 1; send("R6 keep");
    set_mode(6'b00_1000); cond_pass = 1; send("R5 mode off");
    elem_idx = 0; set_mode(6'b00_1010); send("R6 idx0");
    elem_idx = 7'd39; set_mode(6'b00_1110); send("R7 last elem keep");
    elem_idx = 7'd39; set_mode(6'b00_1010); send("R6 last elem drop");
    elem_idx = 7'd20; max_vl = 7'd15; send("R7 clamp by max");
    max_vl = 7'd64;
    // counter-only with everything else asking
    cur_cnt = 0; set_mode(6'b10_1111); cond_pass = 1; send("R8 wrap");
    // masked with all bits
    elem_on = 0; set_mode(6'b11_1111); send("R9 masked");
    set_mode(6'b10_1110); cond_pass = 0; send("R9 masked2");

    for (int i = 0; i < 1500; i++) begin
      elem_on   = ($urandom_range(0, 7) != 0);
      cond_pass = $urandom_range(0, 1);
      set_mode(6'($urandom_range(0, 63)));
      cur_vl    = VL_W'($urandom_range(0, VL_MAX));
      max_vl    = VL_W'($urandom_range(0, VL_MAX));
      elem_idx  = VL_W'($urandom_range(0, VL_MAX - 1));
      ret_addr  = {$urandom, $urandom};
      cur_cnt   = {$urandom, $urandom};
      pick_tag(t);
      send(t);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule